// File: doc/BRIEF.md
# Temporal Region Compactor with LRU Revival

This block follows a stream of retired fetch-block addresses and groups them into spatial regions. A region record holds a trigger block, a bit vector for blocks that come just before the trigger, and a bit vector for blocks that come just after it. While addresses stay inside the current region, the block only sets footprint bits in that region's vectors. When an address falls outside the current region, the block searches a small list of recently retired records, ordered from least to most recently used. A record whose window covers the address becomes the current region again. If no record covers it, the outgoing region is pushed onto the list, handed out on a one-cycle history output, and a fresh region starts at the new address.

The history output is meant to feed a history buffer and a trigger-indexed lookup table. Those sit outside this block. All addresses are block addresses, which means the byte offset has already been removed.

Top module: `tempcomp_top`

## Requirements
- R1: After reset, curValid, histValid and reviveStb are 0 and the record list is empty, so no address can be revived.
- R2: When no current region exists, the first valid address starts a region with curTrigBlk equal to that address and both vectors at zero. No history pulse is emitted and the list is left untouched.
- R3: An address inside the current region window changes only the current vectors. A block equal to the trigger sets no bit. A block at trigger+d with 1<=d<=SUCC_N sets curSucc bit d-1. A block at trigger-d with 1<=d<=PREC_N sets curPrec bit d-1. The list is not touched and no history pulse is emitted.
- R4: An address outside the current window that no list record covers raises histValid for exactly one cycle. The pulse carries the outgoing trigger and vectors, and the current region restarts at the address with empty vectors.
- R5: In the case of R4, the outgoing record is appended at the most recently used end. The list never holds more than DEPTH records. When the list is full, the least recently used record is dropped first and can no longer be revived.
- R6: An address outside the current window that a list record covers makes that record current, with its stored trigger and vectors, and pulses reviveStb for one cycle with no history pulse. The record moves to the most recently used end, and the vectors of the replaced current region are discarded.
- R7: The list search only tests coverage. The revived record does not get the bit for the address that caused the revival.
- R8: When several list records cover the address, the one nearest the least recently used end is revived.
- R9: Every output changes in the cycle after the edge that samples the event. A cycle with retValid low changes no output, and histValid and reviveStb are low in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | A retired block address is presented this cycle |
| retBlk | input | BLK_W | Retired block address |
| curValid | output | 1 | A current region exists |
| curTrigBlk | output | BLK_W | Trigger block of the current region |
| curPrec | output | PREC_N | Footprint of blocks below the trigger (bit d-1 for distance d) |
| curSucc | output | SUCC_N | Footprint of blocks above the trigger (bit d-1 for distance d) |
| histValid | output | 1 | One-cycle pulse: a region record is logged to history |
| histTrigBlk | output | BLK_W | Trigger of the logged record |
| histPrec | output | PREC_N | Lower footprint of the logged record |
| histSucc | output | SUCC_N | Upper footprint of the logged record |
| reviveStb | output | 1 | One-cycle pulse: a listed record became current |

## Verification
The bench builds the block with BLK_W=12, PREC_N=2, SUCC_N=3 and DEPTH=4. Windows this narrow make it easy to place one address under two listed records at once, which exercises the LRU-nearest priority. They also let a few distinct regions fill the list, so the discard of the oldest record becomes visible as a missing revival. A long pseudo-random phase over about two dozen nearby blocks then mixes revivals, in-window hits, duplicated records and evictions, and every output is compared against a queue-based model on each cycle.

// File: rtl/tempcomp_pkg.sv
package tempcomp_pkg;

  // Strobes issued by the control each cycle; at most one event strobe is set.
  typedef struct packed {
    logic startFirst;  // no current region yet: open one
    logic markBit;     // address inside current window: set footprint bit
    logic revive;      // listed record covers address: bring it back
    logic fresh;       // nothing covers address: log and restart
    logic dropLru;     // with fresh: list is full, discard oldest first
  } tcStrb_t;

endpackage

// File: rtl/tempcomp_cover.sv
// Window test: does a region with trigger trigBlk cover probeBlk?
module tempcomp_cover #(
  parameter int BLK_W  = 26,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8
) (
  input  logic             recValid,
  input  logic [BLK_W-1:0] trigBlk,
  input  logic [BLK_W-1:0] probeBlk,
  output logic             covered
);
  localparam logic [BLK_W-1:0] UP_LIM = BLK_W'(SUCC_N);
  localparam logic [BLK_W-1:0] DN_LIM = BLK_W'(PREC_N);

  logic [BLK_W-1:0] upDist;
  logic [BLK_W-1:0] dnDist;

  assign upDist = probeBlk - trigBlk;
  assign dnDist = trigBlk - probeBlk;

  always_comb begin
    covered = 1'b0;
    if (recValid) begin
      if (probeBlk == trigBlk)     covered = 1'b1;
      else if (probeBlk > trigBlk) covered = (upDist <= UP_LIM);
      else                         covered = (dnDist <= DN_LIM);
    end
  end
endmodule

// File: rtl/tempcomp_ctrl.sv
module tempcomp_ctrl
  import tempcomp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retValid,
  input  logic             curValid,
  input  logic             curHit,
  input  logic [DEPTH-1:0] matchVec,
  input  logic             listFull,
  output tcStrb_t          strb,
  output logic [PTR_W-1:0] matchIdx
);
  logic anyMatch;

  assign anyMatch = |matchVec;

  // Lowest index is the least recently used end: it wins.
  always_comb begin
    matchIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) matchIdx = PTR_W'(i);
    end
  end

  always_comb begin
    strb = '0;
    if (retValid) begin
      if (!curValid)     strb.startFirst = 1'b1;
      else if (curHit)   strb.markBit    = 1'b1;
      else if (anyMatch) strb.revive     = 1'b1;
      else begin
        strb.fresh   = 1'b1;
        strb.dropLru = listFull;
      end
    end
  end

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.startFirst, strb.markBit, strb.revive, strb.fresh}));

  assert_drop_only_fresh_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropLru |-> (strb.fresh && listFull));

  assert_pick_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.revive |-> matchVec[matchIdx]);
endmodule

// File: rtl/tempcomp_dp.sv
module tempcomp_dp
  import tempcomp_pkg::*;
#(
  parameter int BLK_W  = 26,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int MAXN  = (PREC_N > SUCC_N) ? PREC_N : SUCC_N,
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1,
  localparam int REC_W = BLK_W + PREC_N + SUCC_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcStrb_t           strb,
  input  logic [PTR_W-1:0]  matchIdx,
  input  logic [BLK_W-1:0]  probeBlk,
  output logic              curHit,
  output logic [DEPTH-1:0]  matchVec,
  output logic              listFull,
  output logic              curValid,
  output logic [BLK_W-1:0]  curTrigBlk,
  output logic [PREC_N-1:0] curPrec,
  output logic [SUCC_N-1:0] curSucc,
  output logic              histValid,
  output logic [BLK_W-1:0]  histTrigBlk,
  output logic [PREC_N-1:0] histPrec,
  output logic [SUCC_N-1:0] histSucc,
  output logic              reviveStb
);
  // Record layout: {trigger, lower footprint, upper footprint}
  localparam int SUCC_LO = 0;
  localparam int PREC_LO = SUCC_N;
  localparam int TRIG_LO = SUCC_N + PREC_N;

  logic [REC_W-1:0] ent [DEPTH];
  logic [REC_W-1:0] entN [DEPTH];
  logic [CNT_W-1:0] cnt, cntN;

  logic [BLK_W-1:0]  spatTrig, spatTrigN;
  logic [PREC_N-1:0] spatPrec, spatPrecN;
  logic [SUCC_N-1:0] spatSucc, spatSuccN;
  logic              spatValidN;
  logic [REC_W-1:0]  spatRec;
  logic [REC_W-1:0]  histRec, histRecN;
  logic              histValidN, reviveN;

  logic [BLK_W-1:0] upDist, dnDist;
  logic             above;
  logic [IDX_W-1:0] bitIdx;
  logic [REC_W-1:0] pickRec;

  assign spatRec = {spatTrig, spatPrec, spatSucc};
  assign listFull = (cnt == CNT_W'(DEPTH));
  assign pickRec  = ent[matchIdx];

  // Window test on the current region
  tempcomp_cover #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N)) spatCover_i (
    .recValid (curValid),
    .trigBlk  (spatTrig),
    .probeBlk (probeBlk),
    .covered  (curHit)
  );

  // One comparator per list slot, all searched at once
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      logic slotLive;
      assign slotLive = (CNT_W'(g) < cnt);
      tempcomp_cover #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N)) slotCover_i (
        .recValid (slotLive),
        .trigBlk  (ent[g][TRIG_LO +: BLK_W]),
        .probeBlk (probeBlk),
        .covered  (matchVec[g])
      );
    end
  endgenerate

  // Footprint bit position relative to the current trigger
  assign above  = (probeBlk > spatTrig);
  assign upDist = probeBlk - spatTrig;
  assign dnDist = spatTrig - probeBlk;
  assign bitIdx = above ? IDX_W'(upDist - 1'b1) : IDX_W'(dnDist - 1'b1);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) entN[i] = ent[i];
    cntN       = cnt;
    spatValidN = curValid;
    spatTrigN  = spatTrig;
    spatPrecN  = spatPrec;
    spatSuccN  = spatSucc;
    histValidN = 1'b0;
    histRecN   = histRec;
    reviveN    = 1'b0;

    if (strb.startFirst) begin
      spatValidN = 1'b1;
      spatTrigN  = probeBlk;
      spatPrecN  = '0;
      spatSuccN  = '0;
    end

    if (strb.markBit && (probeBlk != spatTrig)) begin
      if (above) spatSuccN[bitIdx] = 1'b1;
      else       spatPrecN[bitIdx] = 1'b1;
    end

    if (strb.revive) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if ((i >= int'(matchIdx)) && (i < int'(cnt) - 1)) entN[i] = ent[i + 1];
      end
      entN[PTR_W'(cnt - 1'b1)] = pickRec;
      spatTrigN = pickRec[TRIG_LO +: BLK_W];
      spatPrecN = pickRec[PREC_LO +: PREC_N];
      spatSuccN = pickRec[SUCC_LO +: SUCC_N];
      reviveN   = 1'b1;
    end

    if (strb.fresh) begin
      histValidN = 1'b1;
      histRecN   = spatRec;
      if (strb.dropLru) begin
        for (int i = 0; i < DEPTH - 1; i++) entN[i] = ent[i + 1];
        entN[DEPTH - 1] = spatRec;
      end else begin
        entN[PTR_W'(cnt)] = spatRec;
        cntN = cnt + 1'b1;
      end
      spatTrigN = probeBlk;
      spatPrecN = '0;
      spatSuccN = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      cnt       <= '0;
      curValid  <= 1'b0;
      spatTrig  <= '0;
      spatPrec  <= '0;
      spatSucc  <= '0;
      histValid <= 1'b0;
      histRec   <= '0;
      reviveStb <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= entN[i];
      cnt       <= cntN;
      curValid  <= spatValidN;
      spatTrig  <= spatTrigN;
      spatPrec  <= spatPrecN;
      spatSucc  <= spatSuccN;
      histValid <= histValidN;
      histRec   <= histRecN;
      reviveStb <= reviveN;
    end
  end

  assign curTrigBlk  = spatTrig;
  assign curPrec     = spatPrec;
  assign curSucc     = spatSucc;
  assign histTrigBlk = histRec[TRIG_LO +: BLK_W];
  assign histPrec    = histRec[PREC_LO +: PREC_N];
  assign histSucc    = histRec[SUCC_LO +: SUCC_N];

  assert_list_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  assert_full_stays_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fresh && listFull) |=> listFull);

  assert_fresh_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.fresh |=> (histValid && (curTrigBlk == $past(probeBlk))
                    && (curPrec == '0) && (curSucc == '0)));

  assert_revive_keeps_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.revive |=> ($stable(cnt) && reviveStb && !histValid));

  assert_hit_spares_list_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.markBit |=> ($stable(cnt) && !histValid && $stable(curTrigBlk)));

  assert_first_no_history_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFirst |=> (curValid && !histValid && $stable(cnt)));
endmodule

// File: rtl/tempcomp_top.sv
module tempcomp_top
  import tempcomp_pkg::*;
#(
  parameter int BLK_W  = 26,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic [BLK_W-1:0]  retBlk,
  output logic              curValid,
  output logic [BLK_W-1:0]  curTrigBlk,
  output logic [PREC_N-1:0] curPrec,
  output logic [SUCC_N-1:0] curSucc,
  output logic              histValid,
  output logic [BLK_W-1:0]  histTrigBlk,
  output logic [PREC_N-1:0] histPrec,
  output logic [SUCC_N-1:0] histSucc,
  output logic              reviveStb
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tcStrb_t          strb;
  logic [PTR_W-1:0] matchIdx;
  logic             curHit;
  logic [DEPTH-1:0] matchVec;
  logic             listFull;

  tempcomp_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .retValid (retValid),
    .curValid (curValid),
    .curHit   (curHit),
    .matchVec (matchVec),
    .listFull (listFull),
    .strb     (strb),
    .matchIdx (matchIdx)
  );

  tempcomp_dp #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N), .DEPTH(DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .matchIdx    (matchIdx),
    .probeBlk    (retBlk),
    .curHit      (curHit),
    .matchVec    (matchVec),
    .listFull    (listFull),
    .curValid    (curValid),
    .curTrigBlk  (curTrigBlk),
    .curPrec     (curPrec),
    .curSucc     (curSucc),
    .histValid   (histValid),
    .histTrigBlk (histTrigBlk),
    .histPrec    (histPrec),
    .histSucc    (histSucc),
    .reviveStb   (reviveStb)
  );
endmodule

// File: tb/tempcomp_top_tb_top.sv
`timescale 1ns/1ps
module tempcomp_top_tb_top;
  localparam int BLK_W  = 12;
  localparam int PREC_N = 2;
  localparam int SUCC_N = 3;
  localparam int DEPTH  = 4;
  localparam time CLK_P = 20ns;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              retValid = 1'b0;
  logic [BLK_W-1:0]  retBlk = '0;
  logic              curValid;
  logic [BLK_W-1:0]  curTrigBlk;
  logic [PREC_N-1:0] curPrec;
  logic [SUCC_N-1:0] curSucc;
  logic              histValid;
  logic [BLK_W-1:0]  histTrigBlk;
  logic [PREC_N-1:0] histPrec;
  logic [SUCC_N-1:0] histSucc;
  logic              reviveStb;

  always #(CLK_P / 2) clk = ~clk;

  tempcomp_top #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retBlk(retBlk),
    .curValid(curValid), .curTrigBlk(curTrigBlk), .curPrec(curPrec), .curSucc(curSucc),
    .histValid(histValid), .histTrigBlk(histTrigBlk), .histPrec(histPrec),
    .histSucc(histSucc), .reviveStb(reviveStb)
  );

  // ---------------- reference model ----------------
  typedef struct {
    int                trig;
    logic [PREC_N-1:0] p;
    logic [SUCC_N-1:0] s;
  } mrec_t;

  mrec_t mq[$];
  mrec_t mCur;
  bit    mCurV;
  mrec_t mHist;
  bit    mHistV;
  bit    mRev;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic bit inWindow(int trig, int b);
    if (b == trig) return 1'b1;
    if (b > trig) return (b - trig) <= SUCC_N;
    return (trig - b) <= PREC_N;
  endfunction

  function automatic void modelReset();
    mq.delete();
    mCurV = 1'b0;
    mCur = '{0, '0, '0};
    mHistV = 1'b0;
    mRev = 1'b0;
  endfunction

  function automatic void modelStep(bit v, int b);
    int hitAt;
    mHistV = 1'b0;
    mRev = 1'b0;
    if (!v) return;
    if (!mCurV) begin
      mCurV = 1'b1;
      mCur = '{b, '0, '0};
    end else if (inWindow(mCur.trig, b)) begin
      if (b > mCur.trig) mCur.s[b - mCur.trig - 1] = 1'b1;
      else if (b < mCur.trig) mCur.p[mCur.trig - b - 1] = 1'b1;
    end else begin
      hitAt = -1;
      foreach (mq[k]) if (hitAt < 0 && inWindow(mq[k].trig, b)) hitAt = k;
      if (hitAt >= 0) begin
        mCur = mq[hitAt];
        mq.delete(hitAt);
        mq.push_back(mCur);
        mRev = 1'b1;
      end else begin
        if (mq.size() == DEPTH) void'(mq.pop_front());
        mq.push_back(mCur);
        mHist = mCur;
        mHistV = 1'b1;
        mCur = '{b, '0, '0};
      end
    end
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    bit ok;
    ok = (curValid == mCurV) && (histValid == mHistV) && (reviveStb == mRev);
    if (mCurV) ok = ok && (int'(curTrigBlk) == mCur.trig) && (curPrec == mCur.p) && (curSucc == mCur.s);
    if (mHistV) ok = ok && (int'(histTrigBlk) == mHist.trig) && (histPrec == mHist.p) && (histSucc == mHist.s);
    check(ok, tag,
      $sformatf("cv=%0b ct=%0d cp=%b cs=%b hv=%0b ht=%0d hp=%b hs=%b rv=%0b",
                curValid, curTrigBlk, curPrec, curSucc, histValid, histTrigBlk, histPrec, histSucc, reviveStb),
      $sformatf("cv=%0b ct=%0d cp=%b cs=%b hv=%0b ht=%0d hp=%b hs=%b rv=%0b",
                mCurV, mCur.trig, mCur.p, mCur.s, mHistV, mHist.trig, mHist.p, mHist.s, mRev));
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic cycle(bit v, int b, string tag);
    retValid = v;
    retBlk = BLK_W'(b);
    modelStep(v, b);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    retValid = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(curValid == 1'b0 && histValid == 1'b0 && reviveStb == 1'b0, "R1 reset outputs",
          $sformatf("%0b%0b%0b", curValid, histValid, reviveStb), "000");
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    doReset();

    cycle(1'b0, 0, "R9 idle after reset");
    cycle(1'b1, 100, "R2 first region");
    cycle(1'b1, 101, "R3 succ d=1");
    cycle(1'b1, 103, "R3 succ d=3 edge");
    cycle(1'b1, 99, "R3 prec d=1");
    cycle(1'b1, 100, "R3 same block");
    cycle(1'b1, 104, "R4 beyond window logs 100");
    check(histValid && histTrigBlk == 12'd100 && histPrec == 2'b01 && histSucc == 3'b101,
          "R4 logged record", $sformatf("%0b %0d %b %b", histValid, histTrigBlk, histPrec, histSucc), "1 100 01 101");
    cycle(1'b0, 0, "R9 history pulse drops");
    cycle(1'b1, 105, "R3 succ on 104");
    cycle(1'b1, 200, "R4 logs 104");
    cycle(1'b1, 102, "R8 two covers, oldest wins");
    check(reviveStb && curTrigBlk == 12'd100, "R8 revived trigger",
          $sformatf("%0b %0d", reviveStb, curTrigBlk), "1 100");
    check(curSucc == 3'b101, "R7 no bit set by search", $sformatf("%b", curSucc), "101");
    cycle(1'b1, 102, "R3 bit on revived region");
    cycle(1'b1, 300, "R5 append dup");
    cycle(1'b1, 400, "R5 list full");
    cycle(1'b1, 500, "R5 full drops oldest 104");
    cycle(1'b1, 105, "R5 evicted record not revived");
    check(histValid && !reviveStb && histTrigBlk == 12'd500, "R5 eviction seen",
          $sformatf("%0b %0b %0d", histValid, reviveStb, histTrigBlk), "1 0 500");
    cycle(1'b1, 401, "R6 revive 400");
    check(reviveStb && !histValid && curTrigBlk == 12'd400 && curSucc == 3'b000, "R6 revive discards old bits",
          $sformatf("%0b %0b %0d %b", reviveStb, histValid, curTrigBlk, curSucc), "1 0 400 000");
    cycle(1'b0, 0, "R9 idle");
    cycle(1'b0, 0, "R9 idle hold");

    doReset();
    cycle(1'b1, 300, "R1 list empty after reset");
    cycle(1'b1, 500, "R1 old record gone");
    check(!reviveStb && histValid && histTrigBlk == 12'd300, "R1 no revival after reset",
          $sformatf("%0b %0b %0d", reviveStb, histValid, histTrigBlk), "0 1 300");

    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[1:0] != 2'b00, 50 + int'(lfsr[15:4]) % 24, "R6 random stream");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule